// File: doc/BRIEF.md
# Addressable RGB LED Chain Serializer

This block refreshes a chain of addressable RGB LEDs that take a serial clock and a serial data wire. A one-cycle start pulse together with an LED count launches a refresh. The block first sends thirty-two zero bits. It then sends one 32-bit word per LED, pulling the red, green and blue bytes of each pixel from an upstream source through a valid/ready handshake. A closing trailer follows.

Each LED in the chain regenerates the clock and passes the data on one edge later, so a long chain needs extra edges at the end. Some LED variants also latch only after a long run of zero bits and one more rising edge. For these reasons the trailer is sized from the count of the current refresh: a single all-ones byte, then five zero bytes plus one more zero byte for every sixteen LEDs.

The serial clock is the system clock divided by an even parameter. Busy and done outputs let a controller pace refreshes.

Top module: `rgb_chain_tx`

## Requirements
- R1: Out of reset and whenever busy is low, sclk, sdata, busy, done and px_ready are all low.
- R2: Every refresh opens with four bytes of 0x00 (32 zero bits).
- R3: Each LED word is four bytes in this order: 0xFF, blue, green, red. Bits go out MSB first and are sampled on the rising edge of sclk. sdata changes only while sclk is low.
- R4: After the last LED word, exactly one 0xFF byte is sent.
- R5: After that byte, 5 + floor(count/16) bytes of 0x00 are sent, where count is the 10-bit led_count captured at start.
- R6: A count of zero sends only the four opening zero bytes, one 0xFF byte and five zero bytes.
- R7: done is high for exactly one cycle, on the first cycle after the last trailer bit completes. busy is high from the cycle after an accepted start up to that cycle, and low in it.
- R8: A start pulse that arrives while busy is high is ignored and does not change the byte stream.
- R9: If no pixel is valid when an LED word is due, sclk stays low between bytes and no partial byte is sent.
- R10: While a byte is being shifted, each sclk high phase lasts CLK_DIV/2 system cycles. CLK_DIV must be even and at least 2.
- R11: Exactly count pixels are accepted per refresh (px_valid and px_ready both high at a clock edge), and px_ready is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a refresh |
| led_count | input | 10 | Number of LEDs to refresh, captured at start |
| px_valid | input | 1 | Pixel source holds a valid pixel |
| px_red | input | 8 | Red byte of the offered pixel |
| px_green | input | 8 | Green byte of the offered pixel |
| px_blue | input | 8 | Blue byte of the offered pixel |
| px_ready | output | 1 | Block accepts the offered pixel this cycle |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the chain |
| busy | output | 1 | Refresh in progress |
| done | output | 1 | One-cycle pulse when a refresh finishes |

## Verification
The bench builds the block with CLK_DIV = 4, which selects the counted-phase variant of the bit timer and gives two-cycle clock phases. Those phases can be measured against R10. COUNT_W stays at its default of 10. Counts of 16, 17 and 40 reach the points where the trailer grows by one or two zero bytes. The stalling runs hold the pixel source idle for longer than a byte time, which shows whether the serializer stops cleanly at a byte boundary.

// File: rtl/rgb_chain_pkg.sv
package rgb_chain_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_FETCH,
      ST_WORD,
      ST_MARK,
      ST_TAIL,
      ST_FIN
   } seq_state_t;
endpackage

// File: rtl/rgb_chain_shifter.sv
module rgb_chain_shifter
   import rgb_chain_pkg::*;
#(
   parameter int CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   output logic              active,
   output logic              sclk,
   output logic              sdata
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int BIT_W = $clog2(BYTE_W);

   logic              active_q;
   logic              sclk_q;
   logic              sdata_q;
   logic [BIT_W-1:0]  bit_idx;
   logic [BYTE_W-1:0] shreg;
   logic              phase_end;

   // Variant selection: a one-cycle phase needs no counter
   if (HALF == 1) begin : g_fast
      assign phase_end = active_q;
   end else begin : g_counted
      localparam int PW = $clog2(HALF);
      logic [PW-1:0] ph_cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || !active_q) begin
            ph_cnt <= '0;
         end else if (ph_cnt == PW'(HALF - 1)) begin
            ph_cnt <= '0;
         end else begin
            ph_cnt <= ph_cnt + 1'b1;
         end
      end
      assign phase_end = active_q && (ph_cnt == PW'(HALF - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sclk_q   <= 1'b0;
         sdata_q  <= 1'b0;
         bit_idx  <= '0;
         shreg    <= '0;
      end else if (!active_q) begin
         if (load) begin
            active_q <= 1'b1;
            shreg    <= load_byte;
            sdata_q  <= load_byte[BYTE_W-1];
            sclk_q   <= 1'b0;
            bit_idx  <= '0;
         end
      end else if (phase_end) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else begin
            sclk_q <= 1'b0;
            if (bit_idx == BIT_W'(BYTE_W - 1)) begin
               active_q <= 1'b0;
               sdata_q  <= 1'b0;
            end else begin
               bit_idx <= bit_idx + 1'b1;
               shreg   <= {shreg[BYTE_W-2:0], 1'b0};
               sdata_q <= shreg[BYTE_W-2];
            end
         end
      end
   end

   assign active = active_q;
   assign sclk   = sclk_q;
   assign sdata  = sdata_q;
endmodule

// File: rtl/rgb_chain_seq.sv
module rgb_chain_seq
   import rgb_chain_pkg::*;
#(
   parameter int COUNT_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [COUNT_W-1:0] led_count,
   input  logic               px_valid,
   input  logic [BYTE_W-1:0]  px_red,
   input  logic [BYTE_W-1:0]  px_green,
   input  logic [BYTE_W-1:0]  px_blue,
   output logic               px_ready,
   input  logic               sh_active,
   output logic               sh_load,
   output logic [BYTE_W-1:0]  sh_byte,
   output logic               busy,
   output logic               done
);
   localparam int WORD_BYTES = 4;
   localparam int IDX_W      = $clog2(WORD_BYTES);
   localparam int TAIL_BASE  = 5;
   localparam int GROUP_SH   = 4;

   seq_state_t        state;
   logic [IDX_W-1:0]  byte_idx;
   logic [COUNT_W-1:0] leds_left;
   logic [COUNT_W-1:0] tail_left;
   logic [BYTE_W-1:0] red_q, green_q, blue_q;
   logic              done_q;
   logic              last_of_word;

   assign last_of_word = (byte_idx == IDX_W'(WORD_BYTES - 1));

   always_comb begin
      sh_load = 1'b0;
      sh_byte = '0;
      unique case (state)
         ST_OPEN: sh_load = !sh_active;
         ST_WORD: begin
            sh_load = !sh_active;
            unique case (byte_idx)
               2'd0:    sh_byte = '1;
               2'd1:    sh_byte = blue_q;
               2'd2:    sh_byte = green_q;
               default: sh_byte = red_q;
            endcase
         end
         ST_MARK: begin
            sh_load = !sh_active;
            sh_byte = '1;
         end
         ST_TAIL: sh_load = !sh_active;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         byte_idx  <= '0;
         leds_left <= '0;
         tail_left <= '0;
         red_q     <= '0;
         green_q   <= '0;
         blue_q    <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               state     <= ST_OPEN;
               byte_idx  <= '0;
               leds_left <= led_count;
               tail_left <= COUNT_W'(TAIL_BASE) + (led_count >> GROUP_SH);
            end
            ST_OPEN: if (sh_load) begin
               byte_idx <= byte_idx + 1'b1;
               if (last_of_word) state <= (leds_left == '0) ? ST_MARK : ST_FETCH;
            end
            ST_FETCH: if (px_valid) begin
               red_q     <= px_red;
               green_q   <= px_green;
               blue_q    <= px_blue;
               leds_left <= leds_left - 1'b1;
               byte_idx  <= '0;
               state     <= ST_WORD;
            end
            ST_WORD: if (sh_load) begin
               byte_idx <= byte_idx + 1'b1;
               if (last_of_word) state <= (leds_left == '0) ? ST_MARK : ST_FETCH;
            end
            ST_MARK: if (sh_load) state <= ST_TAIL;
            ST_TAIL: if (sh_load) begin
               tail_left <= tail_left - 1'b1;
               if (tail_left == COUNT_W'(1)) state <= ST_FIN;
            end
            ST_FIN: if (!sh_active) begin
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign px_ready = (state == ST_FETCH);
   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
endmodule

// File: rtl/rgb_chain_tx.sv
module rgb_chain_tx
   import rgb_chain_pkg::*;
#(
   parameter int CLK_DIV = 4,
   parameter int COUNT_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [COUNT_W-1:0] led_count,
   input  logic               px_valid,
   input  logic [7:0]         px_red,
   input  logic [7:0]         px_green,
   input  logic [7:0]         px_blue,
   output logic               px_ready,
   output logic               sclk,
   output logic               sdata,
   output logic               busy,
   output logic               done
);
   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("rgb_chain_tx: CLK_DIV must be even and >= 2");
   end
   if (COUNT_W < 5) begin : g_bad_cnt
      $error("rgb_chain_tx: COUNT_W must be >= 5");
   end

   logic              sh_active;
   logic              sh_load;
   logic [BYTE_W-1:0] sh_byte;

   rgb_chain_seq #(.COUNT_W(COUNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .led_count (led_count),
      .px_valid  (px_valid),
      .px_red    (px_red),
      .px_green  (px_green),
      .px_blue   (px_blue),
      .px_ready  (px_ready),
      .sh_active (sh_active),
      .sh_load   (sh_load),
      .sh_byte   (sh_byte),
      .busy      (busy),
      .done      (done)
   );

   rgb_chain_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_byte (sh_byte),
      .active    (sh_active),
      .sclk      (sclk),
      .sdata     (sdata)
   );
endmodule

// File: rtl/rgb_chain_tx_chk.sv
module rgb_chain_tx_chk #(
   parameter int CLK_DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic sclk,
   input logic sdata,
   input logic px_ready
);
   localparam int HALF = CLK_DIV / 2;

   int unsigned hi_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !sclk) hi_run <= 0;
      else                 hi_run <= hi_run + 1;
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !sdata && !px_ready));

   a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdata));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r10_high_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (hi_run < HALF));

   a_r11_ready_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      px_ready |-> busy);
endmodule

bind rgb_chain_tx rgb_chain_tx_chk #(.CLK_DIV(CLK_DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .sclk     (sclk),
   .sdata    (sdata),
   .px_ready (px_ready)
);

// File: tb/rgb_chain_tx_bench.sv
module rgb_chain_tx_bench;
   localparam int CLK_DIV = 4;
   localparam int HALF    = CLK_DIV / 2;
   localparam int NCASE   = 6;
   localparam int CNT_T [NCASE] = '{0, 1, 3, 16, 17, 40};
   localparam bit STL_T [NCASE] = '{0, 0, 1, 0, 1, 1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [9:0] led_count = '0;
   logic       px_valid;
   logic [7:0] px_red, px_green, px_blue;
   logic       px_ready, sclk, sdata, busy, done;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   rgb_chain_tx #(.CLK_DIV(CLK_DIV), .COUNT_W(10)) u_rgb_chain_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .led_count(led_count),
      .px_valid(px_valid), .px_red(px_red), .px_green(px_green), .px_blue(px_blue),
      .px_ready(px_ready), .sclk(sclk), .sdata(sdata), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pix_r(int i); return 8'(i * 7 + 1);  endfunction
   function automatic logic [7:0] pix_g(int i); return 8'(i * 13 + 2); endfunction
   function automatic logic [7:0] pix_b(int i); return 8'(i) ^ 8'hA5;  endfunction

   function automatic int total_bytes(int n); return 4 + 4 * n + 1 + 5 + n / 16; endfunction

   function automatic logic [7:0] exp_byte(int n, int k);
      int j;
      if (k < 4) return 8'h00;
      j = k - 4;
      if (j < 4 * n) begin
         case (j % 4)
            0:       return 8'hFF;
            1:       return pix_b(j / 4);
            2:       return pix_g(j / 4);
            default: return pix_r(j / 4);
         endcase
      end
      j = j - 4 * n;
      if (j == 0) return 8'hFF;
      return 8'h00;
   endfunction

   // monitor state
   logic [7:0] cap [0:511];
   logic [7:0] shreg;
   int  nbits, nbytes, hi_len, hi_viol, done_cnt, hs_cnt;
   bit  prev_sclk;
   // pixel source state
   bit  stall_mode;
   int  px_idx, tick, stall_run;

   task automatic clear_mon();
      nbits = 0; nbytes = 0; hi_len = 0; hi_viol = 0;
      done_cnt = 0; hs_cnt = 0; px_idx = 0; stall_run = 0;
   endtask

   always @(negedge clk) begin
      if (sclk && !prev_sclk) begin
         shreg = {shreg[6:0], sdata};
         nbits++;
         if (nbits % 8 == 0 && nbytes < 512) begin
            cap[nbytes] = shreg;
            nbytes++;
         end
      end
      if (sclk) hi_len++;
      else begin
         if (prev_sclk && hi_len != HALF) hi_viol++;
         hi_len = 0;
      end
      prev_sclk = sclk;
      if (done) done_cnt++;
   end

   // pixel source: a handshake seen here completes at the coming posedge
   always @(negedge clk) begin
      tick++;
      px_valid = !stall_mode || (tick % 200 >= 150);
      px_red   = pix_r(px_idx);
      px_green = pix_g(px_idx);
      px_blue  = pix_b(px_idx);
      if (px_valid && px_ready) begin
         hs_cnt++;
         px_idx++;
      end
      if (px_ready && !px_valid) begin
         stall_run++;
         if (stall_run == 9 * CLK_DIV + 4)
            chk((nbits % 8 == 0) && !sclk, "R9 stall on byte boundary", nbits % 8, 0);
      end else stall_run = 0;
   end

   task automatic run_case(input int n, input bit stl);
      int cyc;
      int bad;
      clear_mon();
      stall_mode = stl;
      @(negedge clk);
      start = 1'b1; led_count = 10'(n);
      @(negedge clk);
      start = 1'b0; led_count = '0;
      chk(busy, "R7 busy after start", busy, 1);
      repeat (40) @(negedge clk);
      start = 1'b1; led_count = 10'd2;          // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (busy && cyc < 30000) begin @(negedge clk); cyc++; end
      chk(done, "R7 done when busy falls", done, 1);
      repeat (40) @(negedge clk);
      chk(nbytes == total_bytes(n), "R2 R4 R5 R6 R8 byte total", nbytes, total_bytes(n));
      chk(nbits % 8 == 0, "R9 whole bytes only", nbits % 8, 0);
      bad = 0;
      for (int k = 0; k < nbytes && k < total_bytes(n); k++) begin
         if (cap[k] !== exp_byte(n, k)) begin
            bad++;
            $display("FAIL R3 R4 R5 byte %0d of count %0d actual=%0h expected=%0h",
                     k, n, cap[k], exp_byte(n, k));
         end
      end
      n_chk++; if (bad != 0) n_fail++;
      chk(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
      chk(hs_cnt == n, "R11 pixels accepted", hs_cnt, n);
      chk(hi_viol == 0, "R10 high phase length", hi_viol, 0);
      chk(!sclk && !sdata && !busy && !px_ready, "R1 idle after refresh",
          {sclk, sdata, busy, px_ready}, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      stall_mode = 0; tick = 0; prev_sclk = 0; shreg = '0;
      clear_mon();
      repeat (3) @(negedge clk);
      chk({sclk, sdata, busy, done, px_ready} == 5'b0, "R1 reset state",
          {sclk, sdata, busy, done, px_ready}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !sclk, "R1 idle after reset release", {busy, sclk}, 0);

      for (int c = 0; c < NCASE; c++) run_case(CNT_T[c], STL_T[c]);

      // directed: reset in the middle of a refresh
      stall_mode = 0;
      @(negedge clk); start = 1'b1; led_count = 10'd8;
      @(negedge clk); start = 1'b0;
      repeat (100) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({sclk, sdata, busy, px_ready} == 4'b0, "R1 reset mid refresh",
          {sclk, sdata, busy, px_ready}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_case(2, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule